// File: doc/BRIEF.md
# Interrupt Acknowledge Arbitration Unit

When several interrupt sources request service at the same priority level, one of them has to answer the processor's acknowledge cycle. This unit makes that choice. Every source carries a programmable 4-bit arbitration ID. When an acknowledge strobe arrives with a level, the sources requesting at exactly that level with a nonzero ID compete, and the largest ID wins. The result is a one-hot grant, or a no-winner flag that lets outside logic end the cycle as spurious or autovectored.

The last two request lines belong to one two-channel transfer engine. Both channels use a single ID register, so writing or reading the ID through either channel reaches the same bits. All IDs reset to zero, which keeps every source out of arbitration until software programs it. Each module must have its own ID. If two competing sources that use different ID registers hold the same value, the unit raises a configuration-error flag.

The decision is captured once, at the start of a strobe, and held until the strobe ends.

Top module: `irq_ack_arbiter`

## Requirements
- R1: After reset every ID register reads 0, and an acknowledge with any request pattern returns no winner until an ID has been written.
- R2: A cycle with `id_wr_en` high writes `id_wdata` into the ID register of source `id_wr_sel`. Sources NUM_SRC-2 and NUM_SRC-1 use one shared register. `id_rdata` shows the register of source `id_rd_sel` in the same cycle and reads 0 for an index of NUM_SRC or above. A write to such an index changes nothing.
- R3: Only sources with a request high and a level equal to `iack_level` compete. Other sources never receive the grant.
- R4: A source whose ID is 0 never receives the grant, even when it is requesting at the acknowledged level.
- R5: Among the competing sources, the one with the numerically largest ID wins (15 is the best, 1 the worst).
- R6: If both channels of the shared pair compete and hold the best ID, the lower-numbered channel (NUM_SRC-2) wins, and this is not a configuration error.
- R7: `id_conflict_o` is set when two competing sources from different ID registers hold equal nonzero IDs. In a tie for the best ID, the lowest-numbered source wins.
- R8: If no source competes, `no_winner_o` is 1 and `grant_o` is all zero.
- R9: The decision is taken at the first rising edge where `iack_stb` is high and no capture is active. The outputs change after that edge and then stay unchanged for as long as the strobe stays high, whatever the other inputs do. A write in the capture cycle takes effect only for later strobes.
- R10: At the first rising edge where `iack_stb` is low, `grant_o`, `no_winner_o` and `id_conflict_o` all return to 0.
- R11: `grant_o` is always zero or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Per-source request lines |
| src_level | input | NUM_SRC*LVL_W | Per-source priority level, source s in bits [s*LVL_W +: LVL_W] |
| id_wr_en | input | 1 | ID write strobe |
| id_wr_sel | input | SEL_W | Source whose ID is written |
| id_wdata | input | ID_W | ID value to write |
| id_rd_sel | input | SEL_W | Source whose ID is read |
| id_rdata | output | ID_W | ID of the selected source |
| iack_stb | input | 1 | Acknowledge strobe |
| iack_level | input | LVL_W | Level being acknowledged |
| grant_o | output | NUM_SRC | One-hot winner |
| no_winner_o | output | 1 | No source competed |
| id_conflict_o | output | 1 | Duplicate nonzero ID among competitors |

## Verification
The bench builds the unit with NUM_SRC=6, LVL_W=3 and ID_W=4. That gives four single sources, the shared pair on lines 4 and 5, and a 3-bit select field in which the values 6 and 7 are out of range. This makes the aliasing of the shared register, writes to an invalid index, all sixteen ID values, and ties both inside and outside the pair reachable. A random phase keeps the levels in a narrow range, so that collisions and duplicate IDs occur often while strobes start and stop at random cycles.

// File: rtl/iaa_pkg.sv
package iaa_pkg;

  // Index of the ID register used by a source; the last two sources share one.
  function automatic int unsigned reg_of_src(input int unsigned src,
                                             input int unsigned nsrc);
    return (src >= nsrc - 1) ? nsrc - 2 : src;
  endfunction

  // Arbitration order of two IDs: larger value wins.
  function automatic logic id_beats(input logic [7:0] a, input logic [7:0] b);
    return a > b;
  endfunction

endpackage

// File: rtl/iaa_id_regs.sv
module iaa_id_regs #(
  parameter int NUM_SRC = 6,
  parameter int ID_W    = 4,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [ID_W-1:0]           wr_data,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [ID_W-1:0]           rd_data,
  output logic [NUM_SRC*ID_W-1:0]   src_id
);
  import iaa_pkg::*;

  localparam int NUM_REG = NUM_SRC - 1;

  logic [NUM_SRC-1:0]  sel_dec;
  logic [NUM_REG-1:0]  reg_hit;
  logic [ID_W-1:0]     regs [NUM_REG];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
    assign sel_dec[s] = wr_en && (wr_sel == SEL_W'(s));
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    if (k == NUM_REG - 1) begin : g_shared
      assign reg_hit[k] = sel_dec[k] | sel_dec[k+1];
    end else begin : g_single
      assign reg_hit[k] = sel_dec[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs[k] <= '0;
      else if (reg_hit[k]) regs[k] <= wr_data;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    localparam int unsigned RIDX = reg_of_src(s, NUM_SRC);
    assign src_id[s*ID_W +: ID_W] = regs[RIDX];
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (rd_sel == SEL_W'(s)) rd_data = src_id[s*ID_W +: ID_W];
    end
  end

  // R2: a write through the upper channel lands in the shared register
  p_shared_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(NUM_SRC - 1)) |=> (regs[NUM_REG-1] == $past(wr_data)));

  // R2: a register whose select is not hit keeps its value
  p_reg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(src_id));

endmodule

// File: rtl/iaa_select.sv
module iaa_select #(
  parameter int NUM_SRC = 6,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [NUM_SRC*LVL_W-1:0]  src_level,
  input  logic [NUM_SRC*ID_W-1:0]   src_id,
  input  logic [LVL_W-1:0]          ack_level,
  output logic [NUM_SRC-1:0]        win_onehot,
  output logic                      win_any,
  output logic                      dup_id
);
  import iaa_pkg::*;

  logic [ID_W-1:0]    ids [NUM_SRC];
  logic [NUM_SRC-1:0] elig;
  logic [ID_W-1:0]    best_id;
  logic [ID_W-1:0]    gid;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
    assign ids[s]  = src_id[s*ID_W +: ID_W];
    assign elig[s] = src_req[s]
                     && (src_level[s*LVL_W +: LVL_W] == ack_level)
                     && (ids[s] != '0);
  end

  always_comb begin
    best_id = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (elig[s] && id_beats(8'(ids[s]), 8'(best_id))) best_id = ids[s];
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    win_onehot = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (!found && elig[s] && ids[s] == best_id) begin
        win_onehot[s] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    dup_id = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int j = i + 1; j < NUM_SRC; j++) begin
        if (elig[i] && elig[j] && ids[i] == ids[j]
            && reg_of_src(i, NUM_SRC) != reg_of_src(j, NUM_SRC))
          dup_id = 1'b1;
      end
    end
  end

  assign win_any = |elig;

  always_comb begin
    gid = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (win_onehot[s]) gid = ids[s];
    end
  end

  // R11: at most one source is chosen
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot));

  // R3/R4: only an eligible source can be chosen
  p_win_elig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_onehot & ~elig) == '0);

  // R8: a winner exists whenever any source competes
  p_win_exists_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> (win_onehot != '0));

  // R5: no competitor holds a larger ID than the chosen one
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    p_win_highest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      elig[s] |-> (ids[s] <= gid));
  end

endmodule

// File: rtl/iaa_hold.sv
module iaa_hold #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stb,
  input  logic [NUM_SRC-1:0] win_onehot,
  input  logic               win_any,
  input  logic               dup_id,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               none_o,
  output logic               conflict_o,
  output logic               active
);
  logic capture;

  assign capture = stb && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_o    <= '0;
      none_o     <= 1'b0;
      conflict_o <= 1'b0;
      active     <= 1'b0;
    end else if (!stb) begin
      grant_o    <= '0;
      none_o     <= 1'b0;
      conflict_o <= 1'b0;
      active     <= 1'b0;
    end else if (capture) begin
      grant_o    <= win_onehot;
      none_o     <= !win_any;
      conflict_o <= dup_id;
      active     <= 1'b1;
    end
  end

  // R9: outputs frozen while the strobe stays high
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stb) |=> ($stable(grant_o) && $stable(none_o) && $stable(conflict_o)));

  // R9: a strobe start always opens a capture
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !active) |=> active);

  // R10: strobe low clears everything at the next edge
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb) |=> (grant_o == '0 && !none_o && !conflict_o && !active));

  // R8: no-winner excludes any grant
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    none_o |-> (grant_o == '0));

endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter #(
  parameter int NUM_SRC = 6,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 4,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [NUM_SRC*LVL_W-1:0]  src_level,
  input  logic                      id_wr_en,
  input  logic [SEL_W-1:0]          id_wr_sel,
  input  logic [ID_W-1:0]           id_wdata,
  input  logic [SEL_W-1:0]          id_rd_sel,
  output logic [ID_W-1:0]           id_rdata,
  input  logic                      iack_stb,
  input  logic [LVL_W-1:0]          iack_level,
  output logic [NUM_SRC-1:0]        grant_o,
  output logic                      no_winner_o,
  output logic                      id_conflict_o
);
  logic [NUM_SRC*ID_W-1:0] src_id;
  logic [NUM_SRC-1:0]      win_onehot;
  logic                    win_any;
  logic                    dup_id;
  logic                    active;

  iaa_id_regs #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(id_wr_en), .wr_sel(id_wr_sel), .wr_data(id_wdata),
    .rd_sel(id_rd_sel), .rd_data(id_rdata),
    .src_id(src_id)
  );

  iaa_select #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .src_req(src_req), .src_level(src_level), .src_id(src_id),
    .ack_level(iack_level),
    .win_onehot(win_onehot), .win_any(win_any), .dup_id(dup_id)
  );

  iaa_hold #(.NUM_SRC(NUM_SRC)) u_hold (
    .clk(clk), .rst_n(rst_n), .stb(iack_stb),
    .win_onehot(win_onehot), .win_any(win_any), .dup_id(dup_id),
    .grant_o(grant_o), .none_o(no_winner_o), .conflict_o(id_conflict_o),
    .active(active)
  );

  // R11: registered grant never names two sources
  p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R10: idle outputs carry nothing while no capture is open
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |-> (grant_o == '0 && !no_winner_o && !id_conflict_o));

endmodule

// File: tb/irq_ack_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_ack_arbiter_tb_top;
  localparam int NS = 6;
  localparam int LW = 3;
  localparam int IW = 4;
  localparam int SW = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NS-1:0]     src_req;
  logic [NS*LW-1:0]  src_level;
  logic              id_wr_en;
  logic [SW-1:0]     id_wr_sel;
  logic [IW-1:0]     id_wdata;
  logic [SW-1:0]     id_rd_sel;
  logic [IW-1:0]     id_rdata;
  logic              iack_stb;
  logic [LW-1:0]     iack_level;
  logic [NS-1:0]     grant_o;
  logic              no_winner_o;
  logic              id_conflict_o;

  always #10 clk = ~clk;

  irq_ack_arbiter #(.NUM_SRC(NS), .LVL_W(LW), .ID_W(IW), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_level(src_level),
    .id_wr_en(id_wr_en), .id_wr_sel(id_wr_sel), .id_wdata(id_wdata),
    .id_rd_sel(id_rd_sel), .id_rdata(id_rdata),
    .iack_stb(iack_stb), .iack_level(iack_level),
    .grant_o(grant_o), .no_winner_o(no_winner_o), .id_conflict_o(id_conflict_o)
  );

  // reference state
  int        m_id [NS-1];
  bit        m_active;
  bit [NS-1:0] m_grant;
  bit        m_none, m_conf;
  int        n_cmp = 0, n_bad = 0;
  string     cur_req = "R1";

  function automatic int reg_for(int s);
    if (s == NS - 1) return NS - 2;
    return s;
  endfunction

  task automatic arbitrate();
    m_grant = '0; m_none = 1; m_conf = 0;
    for (int v = (1 << IW) - 1; v >= 1; v--) begin
      int q[$];
      int seen[$];
      for (int s = 0; s < NS; s++) begin
        if (src_req[s] && src_level[s*LW +: LW] == iack_level && m_id[reg_for(s)] == v) begin
          bit known = 0;
          q.push_back(s);
          foreach (seen[k]) if (seen[k] == reg_for(s)) known = 1;
          if (!known) seen.push_back(reg_for(s));
        end
      end
      if (seen.size() > 1) m_conf = 1;
      if (q.size() > 0 && m_none) begin
        m_grant[q[0]] = 1'b1;
        m_none = 0;
      end
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      foreach (m_id[k]) m_id[k] = 0;
      m_active = 0; m_grant = '0; m_none = 0; m_conf = 0;
    end else begin
      if (!iack_stb) begin
        m_active = 0; m_grant = '0; m_none = 0; m_conf = 0;
      end else if (!m_active) begin
        arbitrate();
        m_active = 1;
      end
      if (id_wr_en && int'(id_wr_sel) < NS) m_id[reg_for(int'(id_wr_sel))] = int'(id_wdata);
    end
  endtask

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int exp_rd;
    exp_rd = (int'(id_rd_sel) < NS) ? m_id[reg_for(int'(id_rd_sel))] : 0;
    check("grant", int'(grant_o), int'(m_grant));
    check("no_winner", int'(no_winner_o), int'(m_none));
    check("conflict", int'(id_conflict_o), int'(m_conf));
    check("rdata", int'(id_rdata), exp_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr_id(int sel, int val);
    id_wr_en = 1; id_wr_sel = SW'(sel); id_wdata = IW'(val);
    tick();
    id_wr_en = 0;
  endtask

  task automatic set_lvl(int s, int l);
    src_level[s*LW +: LW] = LW'(l);
  endtask

  task automatic ack(int lvl, int n);
    iack_stb = 1; iack_level = LW'(lvl);
    repeat (n) tick();
    iack_stb = 0;
    repeat (2) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; src_req = '0; src_level = '0; id_wr_en = 0; id_wr_sel = '0;
    id_wdata = '0; id_rd_sel = '0; iack_stb = 0; iack_level = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1: reset IDs read zero, acknowledge yields no winner
    cur_req = "R1";
    for (int s = 0; s < 8; s++) begin id_rd_sel = SW'(s); tick(); end
    src_req = '1;
    for (int s = 0; s < NS; s++) set_lvl(s, 3);
    ack(3, 3);

    // R2: programming, shared register aliasing, out-of-range select
    cur_req = "R2";
    wr_id(0, 3); wr_id(1, 5); wr_id(2, 0); wr_id(3, 9);
    wr_id(5, 7);
    id_rd_sel = 4; tick(); id_rd_sel = 5; tick();
    wr_id(4, 12);
    id_rd_sel = 5; tick();
    wr_id(6, 15); wr_id(7, 1);
    for (int s = 0; s < 8; s++) begin id_rd_sel = SW'(s); tick(); end

    // R3: only matching levels compete
    cur_req = "R3";
    src_req = '1;
    set_lvl(0, 2); set_lvl(1, 2); set_lvl(2, 2); set_lvl(3, 5); set_lvl(4, 5); set_lvl(5, 5);
    ack(2, 3); ack(5, 3); ack(6, 2);

    // R4: zero ID excluded even when alone
    cur_req = "R4";
    src_req = 6'b000100; set_lvl(2, 4);
    ack(4, 3);

    // R5: largest ID wins
    cur_req = "R5";
    src_req = 6'b001011;
    for (int s = 0; s < NS; s++) set_lvl(s, 1);
    ack(1, 3);
    src_req = 6'b000011; ack(1, 2);

    // R6: both channels of the pair, best ID, no conflict
    cur_req = "R6";
    src_req = 6'b110011; ack(1, 3);

    // R7: duplicate ID between different registers
    cur_req = "R7";
    wr_id(1, 9);
    src_req = 6'b001010; ack(1, 3);
    wr_id(0, 9);
    src_req = 6'b001011; ack(1, 3);

    // R8: nothing competes
    cur_req = "R8";
    src_req = '0; ack(1, 3);

    // R9: inputs and IDs move during a held strobe; write in capture cycle
    cur_req = "R9";
    src_req = 6'b001000; iack_stb = 1; iack_level = 1;
    id_wr_en = 1; id_wr_sel = 3; id_wdata = 0;
    tick();
    id_wr_en = 0;
    src_req = '1; tick();
    for (int s = 0; s < NS; s++) set_lvl(s, 6);
    tick(); wr_id(4, 15); tick();
    iack_stb = 0; tick();

    // R10: clear at first low edge, then a back-to-back new strobe
    cur_req = "R10";
    iack_stb = 1; iack_level = 6; tick(); tick();
    iack_stb = 0; tick();
    iack_stb = 1; tick(); iack_stb = 0; tick(); tick();

    // R11: random traffic with narrow level range
    cur_req = "R11";
    for (int c = 0; c < 4000; c++) begin
      src_req = NS'($urandom);
      for (int s = 0; s < NS; s++) set_lvl(s, 1 + ($urandom % 2));
      id_wr_en = ($urandom % 6) == 0;
      id_wr_sel = SW'($urandom);
      id_wdata = IW'($urandom % 5 + 11);
      id_rd_sel = SW'($urandom);
      if (($urandom % 4) == 0) iack_stb = ~iack_stb;
      if (($urandom % 3) == 0) iack_level = LW'(1 + ($urandom % 2));
      tick();
    end
    id_wr_en = 0; iack_stb = 0; tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule